// File: doc/BRIEF.md
# Debounced Push-Button Reset Generator

This block turns a noisy, active-low push-button line and a digital undervoltage flag into a clean system reset. The button line is asynchronous. It is brought into the clock domain through two flip-flops. A press counts only after the synchronized level has stayed low for a minimum number of clock cycles, so contact bounce and short glitches have no effect.

While a counted press lasts, or while the undervoltage flag is high, reset is asserted. Once both causes are gone, reset stays asserted for a fixed hold period and is then released. A new cause that arrives during the hold period starts the full hold period again. The block drives reset in both polarities.

All timing comes from three parameters: the clock rate in kHz, the minimum press width in ms and the hold time in ms. The cycle counts are their products, so a simulation can use small values. The block's own asynchronous init asserts reset at power-up, and the normal hold period follows it.

Top module: `mr_pulse_gen`

## Requirements
- R1: The button line passes through a two-flop synchronizer. A low level that lasts fewer than PRESS_CYC consecutive synchronized samples never asserts reset. Contact bounce made of such short low runs is therefore ignored.
- R2: If the button stays low for PRESS_CYC consecutive synchronized samples, the press is qualified. Counting from the first clock edge that samples the low level, rst_out is high after edge PRESS_CYC+3.
- R3: Reset stays asserted for as long as a qualified press is held.
- R4: On the last clock edge at which a cause is present, the hold period is loaded. rst_out then stays high for HOLD_CYC further edges and goes low on the edge after that.
- R5: rst_out_n is always the complement of rst_out.
- R6: When supply_low is high at a clock edge, rst_out is high after that edge. The same hold period applies after supply_low falls.
- R7: A qualified press or supply_low that occurs during the hold period restarts the full hold period.
- R8: While por_n is low, rst_out is high at once. After por_n rises, rst_out goes low on clock edge HOLD_CYC+1, provided no cause appears.
- R9: PRESS_CYC equals CLK_KHZ*PRESS_MS and HOLD_CYC equals CLK_KHZ*HOLD_MS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| por_n | input | 1 | Asynchronous block init, active low |
| btn_n | input | 1 | Asynchronous push-button line, low when pressed |
| supply_low | input | 1 | Synchronous undervoltage flag, active high |
| rst_out | output | 1 | System reset, active high |
| rst_out_n | output | 1 | System reset, active low |

## Verification
The assertions check on every cycle four relationships:
- that a qualified press implies the button was sampled low three edges earlier;
- that a qualified press or undervoltage is followed by reset on the next edge;
- that reset is high exactly while fewer than HOLD_CYC+1 quiet edges have passed since the last cause;
- that every release of reset happens after exactly that many quiet edges.

Only the bench's scenarios can show the rest: that bounce trains and a glitch one sample too short have no effect, that a press of exactly the minimum width counts, and that a retrigger late in the hold period extends reset by a full period.

// File: rtl/mr_pulse_gen.sv
module mr_pulse_gen #(
  parameter int CLK_KHZ  = 50000,
  parameter int PRESS_MS = 1,
  parameter int HOLD_MS  = 200
) (
  input  logic clk,
  input  logic por_n,
  input  logic btn_n,
  input  logic supply_low,
  output logic rst_out,
  output logic rst_out_n
);
  localparam int PRESS_CYC = CLK_KHZ * PRESS_MS;
  localparam int HOLD_CYC  = CLK_KHZ * HOLD_MS;
  localparam int LW = $clog2(PRESS_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [1:0]    sync_q;
  logic [LW-1:0] low_cnt;
  logic [HW-1:0] hold_cnt;
  logic          rst_q;
  logic          press_ok;
  logic          cause;

  assign press_ok  = (low_cnt == LW'(PRESS_CYC));
  assign cause     = press_ok | supply_low;
  assign rst_out   = rst_q;
  assign rst_out_n = ~rst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], btn_n};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_cnt <= '0;
    end else if (sync_q[1]) begin
      low_cnt <= '0;
    end else if (!press_ok) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_cnt <= HW'(HOLD_CYC);
      rst_q    <= 1'b1;
    end else if (cause) begin
      hold_cnt <= HW'(HOLD_CYC);
      rst_q    <= 1'b1;
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
      rst_q    <= 1'b1;
    end else begin
      rst_q    <= 1'b0;
    end
  end
endmodule

// File: rtl/mr_pulse_chk.sv
module mr_pulse_chk #(
  parameter int HOLD_CYC = 4
) (
  input logic clk,
  input logic por_n,
  input logic btn_n,
  input logic supply_low,
  input logic rst_out,
  input logic qualified
);
  localparam int QW = $clog2(HOLD_CYC + 3);
  logic [QW-1:0] quiet;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) quiet <= '0;
    else if (qualified || supply_low) quiet <= '0;
    else if (quiet <= QW'(HOLD_CYC)) quiet <= quiet + 1'b1;
  end

  // R1
  press_sampled_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    qualified |-> !$past(btn_n, 3));

  // R2
  press_to_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    qualified |=> rst_out);

  // R6
  supply_to_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    supply_low |=> rst_out);

  // R4
  hold_active_chk: assert property (@(posedge clk) disable iff (!por_n)
    (quiet <= QW'(HOLD_CYC)) |-> rst_out);

  // R7
  hold_done_chk: assert property (@(posedge clk) disable iff (!por_n)
    (quiet > QW'(HOLD_CYC)) |-> !rst_out);

  // R8
  release_time_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out) |-> (quiet == QW'(HOLD_CYC + 1)));
endmodule

bind mr_pulse_gen mr_pulse_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .btn_n(btn_n), .supply_low(supply_low),
  .rst_out(rst_out), .qualified(press_ok)
);

// File: tb/sim_mr_pulse_gen.sv
`timescale 1ns/1ps
module sim_mr_pulse_gen;
  localparam int CLK_KHZ = 1, PRESS_MS = 4, HOLD_MS = 30;
  localparam int PRESS = CLK_KHZ * PRESS_MS;
  localparam int HOLD  = CLK_KHZ * HOLD_MS;

  logic clk = 0, por_n = 0, btn_n = 1, supply_low = 0;
  logic rst_out, rst_out_n;
  int checks = 0, failures = 0;
  string cur_req = "R8 R9";

  mr_pulse_gen #(.CLK_KHZ(CLK_KHZ), .PRESS_MS(PRESS_MS), .HOLD_MS(HOLD_MS)) u0 (
    .clk(clk), .por_n(por_n), .btn_n(btn_n), .supply_low(supply_low),
    .rst_out(rst_out), .rst_out_n(rst_out_n));

  always #2.5 clk = ~clk;

  bit sq[$];
  int low_run, hold_left;
  bit exp_rst;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sq = '{1, 1}; low_run = 0; hold_left = HOLD; exp_rst = 1;
    end else begin
      bit b;
      if (low_run >= PRESS || supply_low) begin hold_left = HOLD; exp_rst = 1; end
      else if (hold_left > 0) begin hold_left--; exp_rst = 1; end
      else exp_rst = 0;
      b = sq.pop_front();
      sq.push_back(btn_n);
      if (!b) low_run = (low_run < PRESS) ? low_run + 1 : PRESS;
      else low_run = 0;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rst_out !== exp_rst) begin
      failures++;
      $display("FAIL %s rst_out actual=%0b expected=%0b t=%0t", cur_req, rst_out, exp_rst, $time);
    end
    checks++;
    if (rst_out_n !== ~exp_rst) begin
      failures++;
      $display("FAIL R5 rst_out_n actual=%0b expected=%0b t=%0t", rst_out_n, ~exp_rst, $time);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(2);
    cur_req = "R8 R9"; por_n = 1;
    cyc(HOLD + 6);
    cur_req = "R1";
    for (int i = 0; i < 10; i++) begin btn_n = 0; cyc(2); btn_n = 1; cyc(2); end
    btn_n = 0; cyc(PRESS - 1); btn_n = 1; cyc(8);
    cur_req = "R2";
    btn_n = 0; cyc(PRESS); btn_n = 1; cyc(10);
    cur_req = "R4";
    cyc(HOLD + 4);
    cur_req = "R3";
    btn_n = 0; cyc(PRESS + 40); btn_n = 1;
    cur_req = "R4"; cyc(HOLD + 5);
    cur_req = "R6";
    supply_low = 1; cyc(7); supply_low = 0; cyc(HOLD + 4);
    supply_low = 1; cyc(1); supply_low = 0; cyc(HOLD + 4);
    cur_req = "R7";
    btn_n = 0; cyc(PRESS + 3); btn_n = 1; cyc(HOLD - 3);
    supply_low = 1; cyc(1); supply_low = 0; cyc(HOLD - 2);
    btn_n = 0; cyc(PRESS + 2); btn_n = 1; cyc(HOLD + 6);
    cur_req = "R8";
    btn_n = 0; cyc(PRESS + 6);
    por_n = 0; cyc(3); btn_n = 1; por_n = 1; cyc(HOLD + 6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule